// File: doc/BRIEF.md
# Bit-Oriented Frame Serialiser with Transparent Zero Insertion

The block turns one synchronous data-link frame into a serial bit stream, one bit per clock, least significant bit of every byte first. A frame is requested with a one-cycle `start` pulse that also carries the 8-bit address and 8-bit control bytes. The block then sends an opening flag, the address, the control byte and the information bytes, which it pulls from a valid/ready byte stream until a byte marked last. After that it sends a 16-bit frame check and a closing flag.

To keep the flag pattern unique on the line, a 0 is inserted after every run of five consecutive 1 bits inside the address, control, information and check fields. The run of ones carries across field and byte boundaries. The flags are sent unaltered and do not count toward the run. The frame check is computed over the unstuffed address, control and information bits. `ser_valid` marks each cycle that carries a line bit. The only gaps are cycles in which the block waits for an information byte that the stream has not yet offered. The information field holds at least one byte.

Top module: `bitframe_tx`

## Requirements
- R1: Out of reset and between frames, `busy`, `ser_valid` and `in_ready` are all low, and no bit is produced without a `start` pulse.
- R2: The first eight strobed bits of a frame are the flag 0,1,1,1,1,1,1,0 in line order (byte value 0x7E, LSB first), sent without any inserted zero.
- R3: The flag is followed by the address byte and then the control byte, both latched at `start` and both LSB first.
- R4: Information bytes are taken on cycles where `in_valid` and `in_ready` are both high. They are sent LSB first in acceptance order, and the byte taken with `in_last` high is the final one.
- R5: Within the address, control, information and check fields, a 0 is inserted after every five consecutive 1 bits. The ones count carries across byte, field and wait boundaries. It is cleared by the inserted 0 and at the start of each frame.
- R6: Flag bits are never followed by an inserted zero and do not add to the ones count.
- R7: The 16-bit check is the ones' complement of a CRC. The CRC uses the generator x^16+x^12+x^5+1, processes bits LSB first (reversed constant 0x8408) and starts from 0xFFFF. It covers the unstuffed address, control and information bits, and its low byte is sent first, LSB first.
- R8: A closing flag 0x7E follows the check field, preceded by an inserted 0 when the check ends in five ones. `busy` falls after the closing flag's last bit.
- R9: `in_ready` is high only in two cases: during the unstuffed final bit of the control byte or of a non-final information byte, or while the block waits for an information byte with no inserted zero pending. It is never high in flag, address, check or inserted-zero cycles.
- R10: A `start` pulse while a frame is in progress is ignored and does not alter the frame on the line.
- R11: While a frame is in progress, `ser_valid` is low only in cycles where `in_ready` is high because the block waits for an information byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle frame request, taken only when idle |
| hdr_addr | input | 8 | Address byte, latched with `start` |
| hdr_ctrl | input | 8 | Control byte, latched with `start` |
| in_data | input | 8 | Information byte offered on the stream |
| in_valid | input | 1 | Stream byte valid |
| in_last | input | 1 | Marks the final information byte |
| in_ready | output | 1 | Block takes the offered byte this cycle |
| busy | output | 1 | A frame is in progress |
| ser_bit | output | 1 | Line bit |
| ser_valid | output | 1 | `ser_bit` carries a line bit this cycle |

## Verification
The assertions assume that a frame carries at least one information byte and that `in_last` is raised only on the last byte the source means to send. They also assume that inputs change only between clock edges. The stimulus drives every input on the falling edge. It keeps a byte and its last marker steady from the cycle it is first offered until the cycle it is taken, and it withdraws `in_valid` only after a transfer, for a programmed number of idle cycles. It never offers a frame without a last-marked byte.

// File: rtl/bitframe_pkg.sv
`timescale 1ns/1ps
package bitframe_pkg;
  localparam int CRC_W = 16;
  localparam logic [7:0] FLAG_PAT = 8'b0111_1110;

  typedef enum logic [2:0] {
    PH_IDLE, PH_OPEN, PH_ADDR, PH_CTRL, PH_DATA, PH_FCS, PH_CLOSE
  } phase_e;

  // One bit of a reflected CRC: the register shifts toward bit 0.
  function automatic logic [CRC_W-1:0] crc_shift(
    input logic [CRC_W-1:0] c,
    input logic             b,
    input logic [CRC_W-1:0] poly_rev
  );
    logic fb;
    fb = c[0] ^ b;
    crc_shift = (c >> 1) ^ (fb ? poly_rev : '0);
  endfunction
endpackage

// File: rtl/bitframe_crc.sv
`timescale 1ns/1ps
module bitframe_crc
  import bitframe_pkg::*;
#(
  parameter logic [CRC_W-1:0] POLY_REV = 16'h8408,
  parameter logic [CRC_W-1:0] INIT     = 16'hFFFF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init,
  input  logic             step,
  input  logic             din,
  output logic [CRC_W-1:0] crc_q,
  output logic [CRC_W-1:0] crc_nxt
);
  always_comb crc_nxt = crc_shift(crc_q, din, POLY_REV);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     crc_q <= INIT;
    else if (init)  crc_q <= INIT;
    else if (step)  crc_q <= crc_nxt;
  end

  // R7: the register only moves on a counted payload bit or a preset
  a_r7_crc_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!init && !step) |=> $stable(crc_q));
endmodule

// File: rtl/bitframe_stuffer.sv
`timescale 1ns/1ps
module bitframe_stuffer #(
  parameter int RUN_LEN = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic emit_stuff,
  input  logic emit_bit,
  input  logic bit_val,
  output logic stuff_req
);
  localparam int CNT_W = $clog2(RUN_LEN + 1);

  logic [CNT_W-1:0] run_q;

  assign stuff_req = (run_q == CNT_W'(RUN_LEN));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 run_q <= '0;
    else if (clr || emit_stuff) run_q <= '0;
    else if (emit_bit)          run_q <= bit_val ? run_q + 1'b1 : '0;
  end

  // R5: the count never passes the run limit
  a_r5_run_cap: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= CNT_W'(RUN_LEN));

  // R5: once five ones are out, the next line bit is the inserted zero
  a_r5_no_bit_at_limit: assert property (@(posedge clk) disable iff (!rst_n)
    stuff_req |-> !emit_bit);
endmodule

// File: rtl/bitframe_tx.sv
`timescale 1ns/1ps
module bitframe_tx
  import bitframe_pkg::*;
#(
  parameter int               FIELD_W  = 8,
  parameter int               RUN_LEN  = 5,
  parameter logic [CRC_W-1:0] POLY_REV = 16'h8408,
  parameter logic [CRC_W-1:0] CRC_INIT = 16'hFFFF
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [FIELD_W-1:0] hdr_addr,
  input  logic [FIELD_W-1:0] hdr_ctrl,
  input  logic [FIELD_W-1:0] in_data,
  input  logic               in_valid,
  input  logic               in_last,
  output logic               in_ready,
  output logic               busy,
  output logic               ser_bit,
  output logic               ser_valid
);
  localparam int IDX_W = $clog2(CRC_W);
  localparam logic [IDX_W-1:0] LAST_FIELD = IDX_W'(FIELD_W - 1);
  localparam logic [IDX_W-1:0] LAST_CRC   = IDX_W'(CRC_W - 1);
  localparam logic [IDX_W-1:0] LAST_FLAG  = IDX_W'(7);

  phase_e             ph;
  logic [IDX_W-1:0]   idx;
  logic [CRC_W-1:0]   sh;
  logic [FIELD_W-1:0] ctrl_q;
  logic               have_q;
  logic               last_q;

  // named internal events
  logic             payload;
  logic             stuff_req;
  logic             stuff_now;
  logic             data_wait;
  logic             bit_go;
  logic             flag_go;
  logic             field_end;
  logic             take;
  logic             frame_go;
  logic [CRC_W-1:0] crc_q;
  logic [CRC_W-1:0] crc_nxt;

  function automatic logic [CRC_W-1:0] widen(input logic [FIELD_W-1:0] b);
    widen = {{(CRC_W - FIELD_W){1'b0}}, b};
  endfunction

  assign payload   = (ph == PH_ADDR) || (ph == PH_CTRL) ||
                     (ph == PH_DATA) || (ph == PH_FCS);
  assign stuff_now = stuff_req && (payload || ph == PH_CLOSE);
  assign data_wait = (ph == PH_DATA) && !have_q;
  assign bit_go    = payload && !stuff_now && !data_wait;
  assign flag_go   = (ph == PH_OPEN) || (ph == PH_CLOSE && !stuff_now);
  assign field_end = bit_go && (idx == ((ph == PH_FCS) ? LAST_CRC : LAST_FIELD));
  assign frame_go  = (ph == PH_IDLE) && start;

  assign in_ready  = (field_end && (ph == PH_CTRL || (ph == PH_DATA && !last_q))) ||
                     (data_wait && !stuff_now);
  assign take      = in_ready && in_valid;
  assign busy      = (ph != PH_IDLE);
  assign ser_valid = stuff_now || bit_go || flag_go;
  assign ser_bit   = bit_go ? sh[0] : (flag_go ? FLAG_PAT[idx[2:0]] : 1'b0);

  bitframe_stuffer #(.RUN_LEN(RUN_LEN)) u_stuff (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (frame_go),
    .emit_stuff (stuff_now),
    .emit_bit   (bit_go),
    .bit_val    (sh[0]),
    .stuff_req  (stuff_req)
  );

  bitframe_crc #(.POLY_REV(POLY_REV), .INIT(CRC_INIT)) u_crc (
    .clk     (clk),
    .rst_n   (rst_n),
    .init    (frame_go),
    .step    (bit_go && ph != PH_FCS),
    .din     (sh[0]),
    .crc_q   (crc_q),
    .crc_nxt (crc_nxt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph     <= PH_IDLE;
      idx    <= '0;
      sh     <= '0;
      ctrl_q <= '0;
      have_q <= 1'b0;
      last_q <= 1'b0;
    end else begin
      if (bit_go) begin
        sh  <= sh >> 1;
        idx <= idx + 1'b1;
      end
      unique case (ph)
        PH_IDLE: if (start) begin
          ph     <= PH_OPEN;
          idx    <= '0;
          sh     <= widen(hdr_addr);
          ctrl_q <= hdr_ctrl;
          have_q <= 1'b0;
          last_q <= 1'b0;
        end
        PH_OPEN: begin
          idx <= idx + 1'b1;
          if (idx == LAST_FLAG) begin
            ph  <= PH_ADDR;
            idx <= '0;
          end
        end
        PH_ADDR: if (field_end) begin
          ph  <= PH_CTRL;
          idx <= '0;
          sh  <= widen(ctrl_q);
        end
        PH_CTRL: if (field_end) begin
          ph     <= PH_DATA;
          idx    <= '0;
          have_q <= take;
          if (take) begin
            sh     <= widen(in_data);
            last_q <= in_last;
          end
        end
        PH_DATA: begin
          if (data_wait) begin
            if (take) begin
              sh     <= widen(in_data);
              last_q <= in_last;
              have_q <= 1'b1;
            end
          end else if (field_end) begin
            idx <= '0;
            if (last_q) begin
              ph <= PH_FCS;
              sh <= ~crc_nxt;
            end else begin
              have_q <= take;
              if (take) begin
                sh     <= widen(in_data);
                last_q <= in_last;
              end
            end
          end
        end
        PH_FCS: if (field_end) begin
          ph  <= PH_CLOSE;
          idx <= '0;
        end
        PH_CLOSE: if (flag_go) begin
          idx <= idx + 1'b1;
          if (idx == LAST_FLAG) ph <= PH_IDLE;
        end
        default: ph <= PH_IDLE;
      endcase
    end
  end

  // R1: nothing moves on the line or the stream while idle
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!ser_valid && !in_ready));

  // R5: an inserted bit is a strobed zero
  a_r5_stuff_is_zero: assert property (@(posedge clk) disable iff (!rst_n)
    stuff_now |-> (ser_valid && !ser_bit));

  // R6: the opening flag is never interrupted by an inserted zero
  a_r6_open_unstuffed: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_OPEN) |-> !stuff_now);

  // R7: the check register sits at its preset through the opening flag
  a_r7_crc_preset: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_OPEN) |-> (crc_q == CRC_INIT));

  // R8: the closing flag follows the check field
  a_r8_close_after_fcs: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_FCS && field_end) |=> (ph == PH_CLOSE));

  // R9: no byte is requested during flags, header, check or inserted bits
  a_r9_ready_phase: assert property (@(posedge clk) disable iff (!rst_n)
    (stuff_now || ph == PH_OPEN || ph == PH_ADDR || ph == PH_FCS ||
     ph == PH_CLOSE) |-> !in_ready);

  // R10: a frame in progress never restarts
  a_r10_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (ph != PH_IDLE && ph != PH_OPEN && start) |=> (ph != PH_OPEN));

  // R11: a gap in the strobe only happens while a byte is requested
  a_r11_gap_only_waiting: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !ser_valid) |-> in_ready);
endmodule

// File: tb/bitframe_tx_tb.sv
`timescale 1ns/1ps
module bitframe_tx_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       start;
  logic [7:0] hdr_addr, hdr_ctrl, in_data;
  logic       in_valid, in_last;
  logic       in_ready, busy, ser_bit, ser_valid;

  int total = 0;
  int bad   = 0;

  bit   ebits [512];
  int   etag  [512];
  bit   obits [512];
  int   n_exp, n_obs;
  logic [7:0] dat [8];
  logic [31:0] seed = 32'h0000_0001;

  always #2 clk = ~clk;

  bitframe_tx u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .hdr_addr(hdr_addr),
    .hdr_ctrl(hdr_ctrl), .in_data(in_data), .in_valid(in_valid),
    .in_last(in_last), .in_ready(in_ready), .busy(busy),
    .ser_bit(ser_bit), .ser_valid(ser_valid)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic string tag_req(input int t);
    case (t)
      0: tag_req = "R2/R6 opening flag";
      1: tag_req = "R3 header";
      2: tag_req = "R4 information";
      3: tag_req = "R7 check field";
      4: tag_req = "R5 inserted zero";
      default: tag_req = "R8 closing flag";
    endcase
  endfunction

  function automatic logic [31:0] lcg();
    seed = seed * 32'd1103515245 + 32'd12345;
    lcg  = seed;
  endfunction

  task automatic push(input bit b, input int t);
    ebits[n_exp] = b;
    etag[n_exp]  = t;
    n_exp++;
  endtask

  // Expected line image, built from the requirements
  task automatic build(input logic [7:0] a, input logic [7:0] c, input int n);
    logic [15:0] crc;
    logic [15:0] fcs;
    logic [7:0]  byt;
    int run;
    int tg;
    crc = 16'hFFFF;
    for (int k = 0; k < n + 2; k++) begin
      byt = (k == 0) ? a : (k == 1) ? c : dat[k-2];
      crc = crc ^ {8'h00, byt};
      for (int i = 0; i < 8; i++)
        crc = crc[0] ? ((crc >> 1) ^ 16'h8408) : (crc >> 1);
    end
    fcs = ~crc;
    n_exp = 0;
    for (int i = 0; i < 8; i++) push(8'h7E >> i & 1, 0);
    run = 0;
    for (int k = 0; k < n + 4; k++) begin
      if (k == 0)          begin byt = a;          tg = 1; end
      else if (k == 1)     begin byt = c;          tg = 1; end
      else if (k < n + 2)  begin byt = dat[k-2];   tg = 2; end
      else if (k == n + 2) begin byt = fcs[7:0];   tg = 3; end
      else                 begin byt = fcs[15:8];  tg = 3; end
      for (int i = 0; i < 8; i++) begin
        push(byt[i], tg);
        run = byt[i] ? run + 1 : 0;
        if (run == 5) begin
          push(1'b0, 4);
          run = 0;
        end
      end
    end
    for (int i = 0; i < 8; i++) push(8'h7E >> i & 1, 5);
  endtask

  task automatic run_frame(input logic [7:0] a, input logic [7:0] c,
                           input int n, input int gap, input bit poke);
    int cyc = 0, ptr = 0, gapc = 0, pos = 0, run = 0, raw = 0;
    int v9 = 0, v11 = 0, ptot, all_mis;
    int mism [6];
    build(a, c, n);
    ptot  = 32 + 8 * n;
    n_obs = 0;
    for (int t = 0; t < 6; t++) mism[t] = 0;
    @(negedge clk);
    start = 1'b1; hdr_addr = a; hdr_ctrl = c; in_valid = 1'b0;
    @(negedge clk);
    start = 1'b0;
    while (busy && cyc < 3000) begin
      bit stf;
      int r;
      stf = 1'b0;
      r   = -1;
      if (ser_valid) begin
        if (n_obs < 512) obits[n_obs] = ser_bit;
        n_obs++;
        if (pos < 8) begin
        end else if (run == 5) begin
          stf = 1'b1;
          run = 0;
        end else if (raw < ptot) begin
          r = raw;
          raw++;
          run = ser_bit ? run + 1 : 0;
        end
        pos++;
      end
      // R9: a byte request must sit on a byte boundary or a wait
      if (in_ready && ser_valid &&
          !(!stf && r >= 15 && r < 16 + 8 * n - 1 && (r % 8) == 7)) v9++;
      // R11: no strobe gap unless a byte is being requested
      if (!ser_valid && !in_ready) v11++;
      start = (poke && cyc == 20);
      if (poke && cyc == 20) begin
        hdr_addr = ~a;
        hdr_ctrl = ~c;
      end
      if (gapc > 0) begin
        gapc--;
        in_valid = 1'b0;
      end else if (ptr < n) begin
        in_valid = 1'b1;
        in_data  = dat[ptr];
        in_last  = (ptr == n - 1);
      end else begin
        in_valid = 1'b0;
      end
      if (in_valid && in_ready) begin
        ptr++;
        gapc = gap;
      end
      @(negedge clk);
      cyc++;
    end
    start    = 1'b0;
    in_valid = 1'b0;
    chk(cyc < 3000, "R8", "frame completes and busy falls", cyc, 3000);
    chk(!ser_valid && !in_ready, "R1", "quiet after frame",
        int'(ser_valid) + int'(in_ready), 0);
    chk(n_obs == n_exp, "R5", "strobed bit count", n_obs, n_exp);
    for (int i = 0; i < n_obs && i < n_exp && i < 512; i++)
      if (obits[i] != ebits[i]) mism[etag[i]]++;
    all_mis = 0;
    for (int t = 0; t < 6; t++) begin
      chk(mism[t] == 0, tag_req(t), "mismatching bits", mism[t], 0);
      all_mis += mism[t];
    end
    chk(ptr == n, "R4", "bytes taken from stream", ptr, n);
    chk(v9 == 0, "R9", "misplaced byte requests", v9, 0);
    chk(v11 == 0, "R11", "unexplained strobe gaps", v11, 0);
    if (poke)
      chk(all_mis == 0 && n_obs == n_exp, "R10", "frame altered by late start",
          all_mis, 0);
  endtask

  initial begin
    #760000;
    bad++;
    total++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; hdr_addr = '0; hdr_ctrl = '0;
    in_data = '0; in_valid = 1'b0; in_last = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: quiet after reset
    chk(!busy && !ser_valid && !in_ready, "R1", "reset state",
        int'(busy) + int'(ser_valid) + int'(in_ready), 0);
    // R1: stream activity alone starts nothing
    in_valid = 1'b1; in_data = 8'hA5; in_last = 1'b1;
    repeat (3) @(negedge clk);
    chk(!busy && !ser_valid && !in_ready, "R1", "no frame without start",
        int'(busy) + int'(ser_valid) + int'(in_ready), 0);
    in_valid = 1'b0;

    // R5: a flag-like data byte gets a zero after its five ones
    dat[0] = 8'h7E;
    run_frame(8'h00, 8'h00, 1, 0, 1'b0);
    // R5: the run carries across address, control and data
    dat[0] = 8'hFF; dat[1] = 8'hFF; dat[2] = 8'h7E;
    run_frame(8'hFF, 8'hFF, 3, 0, 1'b0);
    // R5 R11: stuffing and counting across stream waits
    dat[0] = 8'hFF; dat[1] = 8'h1F; dat[2] = 8'hF8; dat[3] = 8'hFF;
    run_frame(8'hF0, 8'h0F, 4, 3, 1'b0);
    // R10: late start pulse ignored
    dat[0] = 8'h3C; dat[1] = 8'hC3;
    run_frame(8'h12, 8'h34, 2, 1, 1'b1);

    // R7 R8: exhaustive single-byte information field
    for (int d = 0; d < 256; d++) begin
      dat[0] = 8'(d);
      run_frame(8'(d ^ 32'h5A), {dat[0][3:0], dat[0][7:4]}, 1, 0, 1'b0);
    end

    // R4: multi-byte frames with varied stream gaps
    for (int f = 0; f < 24; f++) begin
      int n;
      n = 1 + int'(lcg() >> 8) % 6;
      for (int k = 0; k < n; k++) dat[k] = 8'(lcg() >> 16);
      run_frame(8'(lcg() >> 20), 8'(lcg() >> 12), n, f % 4, (f % 5) == 2);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule